// File: doc/BRIEF.md
# Serial FIFO Pair with Threshold Interrupts

This block sits between a register port and the shift engine of a serial controller. It holds a transmit queue that software fills and the shift engine drains, and a receive queue that the shift engine fills and software drains. Both queues share one parameterised depth. Each direction has a programmable threshold. Five interrupt sources are derived from the levels and from misuse events. They pass through a mask and are OR-ed into one interrupt line.

Software uses one address for data: a write queues a transmit word and a read takes a receive word. Other addresses hold the enable bit, the two thresholds, the two live levels, the mask, the raw and masked status, and a clear-on-read view of the error flags. A threshold write that the depth cannot hold is refused. Because of this, software can find the depth by writing rising values and reading each one back. Clearing the enable bit empties both queues and drops every error flag.

Top module: `sio_fifo_irq`

## Requirements
- R1: After reset the control register (offset 1, bit 0 enable) reads 0, both thresholds (offsets 2, 3) read 0, the mask (offset 6) reads 0, both levels (offsets 4, 5) read 0 and `irq` is low.
- R2: While enabled, a write to offset 0 queues the low data bits on the transmit side, and offset 4 reports the entry count. `tx_data` shows the oldest entry and `tx_pop` removes it, so words leave in write order.
- R3: A write to offset 0 while the transmit level equals the depth is discarded and sets status bit 1 (transmit overflow).
- R4: While enabled, `rx_push` queues `rx_data`, and offset 5 reports the entry count. Reading offset 0 returns and removes the oldest receive entry.
- R5: Reading offset 0 with the receive side empty returns 0, leaves the level at 0 and sets status bit 2 (receive underflow).
- R6: An `rx_push` while the receive level equals the depth is discarded and sets status bit 3 (receive overflow). This holds even if a read occurs in the same cycle.
- R7: Status bit 0 (transmit empty) is 1 exactly while the transmit level is at or below the transmit threshold.
- R8: Status bit 4 (receive full) is 1 exactly while the receive level exceeds the receive threshold, that is, from threshold plus one entries.
- R9: A threshold write of a value at or above the depth leaves the stored threshold unchanged, so reading it back does not return the written value.
- R10: Offset 8 reads the raw status (offset 7) AND the mask (offset 6, same bit order). `irq` is the OR of those bits, so a zero mask keeps `irq` low.
- R11: Bits 1 to 3 stay set until a read of offset 9, which returns them in place and clears them. Bits 0 and 4 follow the levels and are not affected by that read.
- R12: Writing 0 to the enable bit empties both queues and clears bits 1 to 3 at the same edge. While disabled, data writes and `rx_push` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the edge) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | RW | Write data |
| reg_rdata | output | RW | Read data, valid in the strobe cycle |
| tx_pop | input | 1 | Shift engine takes the oldest transmit entry |
| tx_data | output | DW | Oldest transmit entry, 0 when empty |
| tx_empty | output | 1 | Transmit queue holds nothing |
| rx_push | input | 1 | Shift engine delivers a receive word |
| rx_data | input | DW | Receive word |
| irq | output | 1 | Combined masked interrupt |

## Verification
Two situations are hard to reach from the ports. The first is a receive overflow without losing track of the queue contents: the bench has to fill the receive side to the exact depth while a scoreboard records only the accepted words. It then pushes once more and drains, which shows that the extra word never appears. The second is the sticky versus level split: the bench raises all three error flags, leaves the transmit level under its threshold, and checks that a clear read returns only the error bits while bit 0 survives. It then repeats the error buildup with data in both queues before disabling, so the flush has to remove both queues and the flags in one step.

// File: rtl/sio_fifo_pkg.sv
`timescale 1ns/1ps
package sio_fifo_pkg;
    localparam int IRQ_N   = 5;
    localparam int IRQ_TXE = 0;
    localparam int IRQ_TXO = 1;
    localparam int IRQ_RXU = 2;
    localparam int IRQ_RXO = 3;
    localparam int IRQ_RXF = 4;

    localparam logic [3:0] A_DATA  = 4'd0;
    localparam logic [3:0] A_CTRL  = 4'd1;
    localparam logic [3:0] A_TXTHR = 4'd2;
    localparam logic [3:0] A_RXTHR = 4'd3;
    localparam logic [3:0] A_TXLVL = 4'd4;
    localparam logic [3:0] A_RXLVL = 4'd5;
    localparam logic [3:0] A_MASK  = 4'd6;
    localparam logic [3:0] A_RAW   = 4'd7;
    localparam logic [3:0] A_MSTAT = 4'd8;
    localparam logic [3:0] A_CLEAR = 4'd9;

    typedef logic [IRQ_N-1:0] irq_vec_t;
endpackage

// File: rtl/sio_fifo.sv
`timescale 1ns/1ps
module sio_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [LW-1:0] count;
    } fifo_st_t;

    fifo_st_t      st_q, st_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (st_q.count == LW'(DEPTH));
    assign empty   = (st_q.count == '0);
    assign level   = st_q.count;
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = empty ? '0 : mem_q[st_q.rptr];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wptr = ptr_inc(st_q.wptr);
            if (do_pop)  st_d.rptr = ptr_inc(st_q.rptr);
            st_d.count = st_q.count + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wptr] <= wdata;
    end

    // R2 / R4: level never passes the depth
    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= LW'(DEPTH));

    // R3 and R6: a push into a full queue leaves the level alone
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (st_q.count == LW'(DEPTH)));

    // R12: flush empties the queue at the next edge
    assert_flush_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.count == '0));
endmodule

// File: rtl/sio_irq_ctrl.sv
`timescale 1ns/1ps
module sio_irq_ctrl
    import sio_fifo_pkg::*;
#(
    parameter int LW = 4,
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  logic [TW-1:0] tx_thr,
    input  logic [TW-1:0] rx_thr,
    input  logic          ev_txo,
    input  logic          ev_rxu,
    input  logic          ev_rxo,
    input  logic          clr,
    input  logic          flush,
    input  irq_vec_t      mask,
    output irq_vec_t      raw,
    output irq_vec_t      masked,
    output logic          irq
);
    typedef struct packed {
        logic txo;
        logic rxu;
        logic rxo;
    } sticky_t;

    sticky_t sk_q, sk_d;

    always_comb begin
        sk_d = sk_q;
        if (flush) begin
            sk_d = '0;
        end else begin
            sk_d.txo = ev_txo || (sk_q.txo && !clr);
            sk_d.rxu = ev_rxu || (sk_q.rxu && !clr);
            sk_d.rxo = ev_rxo || (sk_q.rxo && !clr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= '0;
        else        sk_q <= sk_d;
    end

    always_comb begin
        raw          = '0;
        raw[IRQ_TXE] = (tx_level <= LW'(tx_thr));
        raw[IRQ_TXO] = sk_q.txo;
        raw[IRQ_RXU] = sk_q.rxu;
        raw[IRQ_RXO] = sk_q.rxo;
        raw[IRQ_RXF] = (rx_level > LW'(rx_thr));
    end

    assign masked = raw & mask;
    assign irq    = |masked;

    // R11: an error flag holds until a clear read or a flush
    assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_q.rxo && !clr && !flush) |=> sk_q.rxo);

    // R11: a clear read with no new event leaves no error flag
    assert_clear_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev_txo && !ev_rxu && !ev_rxo) |=> (sk_q == '0));

    // R10: the line can only be high through an enabled mask bit
    assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != '0));
endmodule

// File: rtl/sio_fifo_irq.sv
`timescale 1ns/1ps
module sio_fifo_irq
    import sio_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int RW    = 16,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [3:0]    reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_data,
    output logic          tx_empty,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_data,
    output logic          irq
);
    typedef struct packed {
        logic          enable;
        logic [TW-1:0] tx_thr;
        logic [TW-1:0] rx_thr;
        irq_vec_t      mask;
    } cfg_t;

    cfg_t          cfg_q, cfg_d;
    logic          wr_data, rd_data, rd_clear, flush;
    logic          thr_ok;
    logic [LW-1:0] tx_level, rx_level;
    logic          tx_full, rx_full, rx_empty;
    logic [DW-1:0] rx_head;
    logic          ev_txo, ev_rxu, ev_rxo;
    irq_vec_t      raw, masked;

    assign wr_data  = reg_wr && (reg_addr == A_DATA);
    assign rd_data  = reg_rd && (reg_addr == A_DATA);
    assign rd_clear = reg_rd && (reg_addr == A_CLEAR);
    assign thr_ok   = (reg_wdata < RW'(DEPTH));

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL:  cfg_d.enable = reg_wdata[0];
                A_TXTHR: if (thr_ok) cfg_d.tx_thr = reg_wdata[TW-1:0];
                A_RXTHR: if (thr_ok) cfg_d.rx_thr = reg_wdata[TW-1:0];
                A_MASK:  cfg_d.mask = reg_wdata[IRQ_N-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // queues drop their contents at the edge where enable falls
    assign flush  = !cfg_d.enable;
    assign ev_txo = cfg_q.enable && wr_data && tx_full;
    assign ev_rxu = cfg_q.enable && rd_data && rx_empty;
    assign ev_rxo = cfg_q.enable && rx_push && rx_full;

    sio_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (wr_data),
        .pop   (tx_pop),
        .wdata (reg_wdata[DW-1:0]),
        .rdata (tx_data),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sio_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (rx_push),
        .pop   (rd_data),
        .wdata (rx_data),
        .rdata (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    sio_irq_ctrl #(.LW(LW), .TW(TW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_thr   (cfg_q.tx_thr),
        .rx_thr   (cfg_q.rx_thr),
        .ev_txo   (ev_txo),
        .ev_rxu   (ev_rxu),
        .ev_rxo   (ev_rxo),
        .clr      (rd_clear),
        .flush    (flush),
        .mask     (cfg_q.mask),
        .raw      (raw),
        .masked   (masked),
        .irq      (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DATA:  reg_rdata = RW'(rx_head);
            A_CTRL:  reg_rdata = RW'(cfg_q.enable);
            A_TXTHR: reg_rdata = RW'(cfg_q.tx_thr);
            A_RXTHR: reg_rdata = RW'(cfg_q.rx_thr);
            A_TXLVL: reg_rdata = RW'(tx_level);
            A_RXLVL: reg_rdata = RW'(rx_level);
            A_MASK:  reg_rdata = RW'(cfg_q.mask);
            A_RAW:   reg_rdata = RW'(raw);
            A_MSTAT: reg_rdata = RW'(masked);
            A_CLEAR: reg_rdata = RW'(raw & irq_vec_t'(5'b01110));
            default: reg_rdata = '0;
        endcase
    end

    // R9: an out-of-range threshold write leaves the stored value alone
    assert_thr_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TXTHR && !thr_ok) |=> $stable(cfg_q.tx_thr));

    // R12: while disabled the transmit queue stays empty
    assert_disabled_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.enable && !cfg_d.enable) |=> tx_empty);
endmodule

// File: tb/sio_fifo_irq_bench.sv
`timescale 1ns/1ps
module sio_fifo_irq_bench;
    localparam int DEPTH = 8;
    localparam int DW    = 8;
    localparam int RW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic          tx_pop = 1'b0;
    logic [DW-1:0] tx_data;
    logic          tx_empty;
    logic          rx_push = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    logic [DW-1:0] txq[$];
    logic [DW-1:0] rxq[$];

    always #2.5 clk = ~clk;

    sio_fifo_irq #(.DEPTH(DEPTH), .DW(DW), .RW(RW)) u_sio_fifo_irq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty),
        .rx_push(rx_push), .rx_data(rx_data), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = RW'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = int'(reg_rdata);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input int m, input int exp);
        int v;
        rd(a, v);
        chk(req, v & m, exp);
    endtask

    // driver: transmit side
    task automatic tx_put(input logic [DW-1:0] d, input bit acc);
        if (acc) txq.push_back(d);
        wr(4'd0, int'(d));
    endtask

    // monitor: transmit side, compares the head against the scoreboard
    task automatic tx_take();
        logic [DW-1:0] e;
        @(negedge clk);
        e = txq.pop_front();
        chk("R2 tx order", int'(tx_data), int'(e));
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    // driver: receive side
    task automatic rx_put(input logic [DW-1:0] d, input bit acc);
        @(negedge clk);
        if (acc) rxq.push_back(d);
        rx_push = 1'b1; rx_data = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    // monitor: receive side
    task automatic rx_take();
        int v;
        logic [DW-1:0] e;
        e = rxq.pop_front();
        rd(4'd0, v);
        chk("R4 rx order", v, int'(e));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 ctrl", 4'd1, 32'hFFFF, 0);
        rd_chk("R1 txthr", 4'd2, 32'hFFFF, 0);
        rd_chk("R1 rxthr", 4'd3, 32'hFFFF, 0);
        rd_chk("R1 txlvl", 4'd4, 32'hFFFF, 0);
        rd_chk("R1 rxlvl", 4'd5, 32'hFFFF, 0);
        rd_chk("R1 mask", 4'd6, 32'hFFFF, 0);
        chk("R1 irq", int'(irq), 0);

        // R9 threshold probing
        wr(4'd2, 5);  rd_chk("R9 txthr in range", 4'd2, 32'hFFFF, 5);
        wr(4'd2, 8);  rd_chk("R9 txthr at depth", 4'd2, 32'hFFFF, 5);
        wr(4'd2, 7);  rd_chk("R9 txthr max", 4'd2, 32'hFFFF, 7);
        wr(4'd3, 9);  rd_chk("R9 rxthr beyond", 4'd3, 32'hFFFF, 0);
        wr(4'd3, 3);  rd_chk("R9 rxthr set", 4'd3, 32'hFFFF, 3);

        // R12 disabled: writes ignored
        tx_put(8'h11, 1'b0);
        rd_chk("R12 disabled tx write", 4'd4, 32'hFFFF, 0);

        wr(4'd1, 1);
        wr(4'd2, 2);

        // R2 / R7 transmit level against threshold
        for (int i = 0; i < 3; i++) tx_put(8'hA0 + 8'(i), 1'b1);
        rd_chk("R2 txlvl", 4'd4, 32'hFFFF, 3);
        rd_chk("R7 above thr", 4'd7, 1, 0);
        tx_take();
        rd_chk("R7 at thr", 4'd7, 1, 1);
        tx_take();
        tx_take();
        chk("R2 tx_empty", int'(tx_empty), 1);

        // R3 transmit overflow
        for (int i = 0; i < DEPTH; i++) tx_put(8'hB0 + 8'(i), 1'b1);
        tx_put(8'hEE, 1'b0);
        rd_chk("R3 txlvl full", 4'd4, 32'hFFFF, DEPTH);
        rd_chk("R3 overflow bit", 4'd7, 2, 2);
        for (int i = 0; i < DEPTH; i++) tx_take();
        rd_chk("R2 txlvl drained", 4'd4, 32'hFFFF, 0);

        // R8 receive threshold plus one
        for (int i = 0; i < 3; i++) rx_put(8'h50 + 8'(i), 1'b1);
        rd_chk("R8 at thr", 4'd7, 16, 0);
        rx_put(8'h53, 1'b1);
        rd_chk("R8 thr plus one", 4'd7, 16, 16);
        rd_chk("R4 rxlvl", 4'd5, 32'hFFFF, 4);

        // R6 receive overflow
        for (int i = 4; i < DEPTH; i++) rx_put(8'h50 + 8'(i), 1'b1);
        rx_put(8'hEE, 1'b0);
        rd_chk("R6 overflow bit", 4'd7, 8, 8);
        rd_chk("R6 rxlvl full", 4'd5, 32'hFFFF, DEPTH);
        for (int i = 0; i < DEPTH; i++) rx_take();

        // R5 underflow
        rd_chk("R5 empty read data", 4'd0, 32'hFFFF, 0);
        rd_chk("R5 underflow bit", 4'd7, 4, 4);
        rd_chk("R5 rxlvl", 4'd5, 32'hFFFF, 0);

        // R10 masking
        chk("R10 mask zero irq", int'(irq), 0);
        wr(4'd6, 2);
        chk("R10 irq on", int'(irq), 1);
        rd_chk("R10 masked", 4'd8, 32'hFFFF, 2);
        wr(4'd6, 16);
        chk("R10 other source", int'(irq), 0);
        rd_chk("R10 masked none", 4'd8, 32'hFFFF, 0);
        wr(4'd6, 0);

        // R11 clear on read
        rd_chk("R11 clear returns", 4'd9, 32'hFFFF, 32'h0E);
        rd_chk("R11 raw after clear", 4'd7, 32'hFFFF, 1);

        // R12 flush on disable
        for (int i = 0; i <= DEPTH; i++) rx_put(8'h70 + 8'(i), 1'b0);
        tx_put(8'hC1, 1'b0);
        tx_put(8'hC2, 1'b0);
        rd_chk("R12 pre flush overflow", 4'd7, 8, 8);
        wr(4'd1, 0);
        rd_chk("R12 txlvl flushed", 4'd4, 32'hFFFF, 0);
        rd_chk("R12 rxlvl flushed", 4'd5, 32'hFFFF, 0);
        rd_chk("R12 flags cleared", 4'd7, 32'hFFFF, 1);
        rx_put(8'h99, 1'b0);
        rd_chk("R12 disabled rx push", 4'd5, 32'hFFFF, 0);
        wr(4'd1, 1);
        rd_chk("R12 reenabled rxlvl", 4'd5, 32'hFFFF, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule